// File: doc/BRIEF.md
# Utility Interrupt Mask and Level Encoder

This block gathers seven utility interrupt sources from a bus-interface device and turns them into one prioritized interrupt level for a local processor. The sources are a low-priority and a high-priority attention signal, two location-monitor hits, completion of an outgoing interrupt's acknowledge cycle, an active-low system-fail line and a bus error seen while a posted write completes. Each source has a sticky pending flag that is set by a new event, whether or not the source is enabled. It also has an enable bit in a CPU-writable register that decides whether that flag may drive the output.

Three sources have fixed levels: low attention is 1, high attention is 5 and the posted-write error is 7. The two location monitors, the acknowledge-complete source and the system-fail source take their levels from small configuration inputs. A master-enable input from a separate interrupt controller gates the whole output. The output is a registered 3-bit level. It carries the highest level among the sources that are both pending and enabled, or 0 when no source qualifies.

Top module: `util_irq_ctrl`

## Requirements
- R1: A write on `en_wr` loads `en_wr_data` into the enable register, which reads back on `en_rd`. The bit positions are: 1 low attention, 2 location monitor 0, 3 acknowledge-complete, 4 location monitor 1, 5 high attention, 6 system fail, 7 posted-write error. Bit 0 is reserved and always reads 0.
- R2: While `rst_n` is low at a clock edge, the enable register, all pending flags and `irq_level` are cleared.
- R3: A source's pending flag, on `pend_rd` at the same bit position, is set at the first clock edge that samples its event high after a low sample. This happens even when the source is disabled. The flag stays set until it is cleared.
- R4: A write on `clr_wr` clears every pending flag whose bit in `clr_wr_data` is 1. If a new event and a clear meet the same flag at the same edge, the flag stays set.
- R5: The low-attention source contributes level 1, the high-attention source level 5 and the posted-write error level 7.
- R6: Location monitor 0, location monitor 1, acknowledge-complete and system fail contribute the level on `lvl_lm0`, `lvl_lm1`, `lvl_iack` and `lvl_sysfail`. A level of 0 contributes nothing.
- R7: The system-fail event is active low: a falling `sysfail_n` sets its pending flag. Holding the line low does not set the flag again after it is cleared.
- R8: When `master_en` was 0 at the previous clock edge, `irq_level` is 0 whatever is pending and enabled.
- R9: At each clock edge, `irq_level` takes the highest level among the sources that are pending and enabled, or 0 if there are none. This uses the flags, enables, level inputs and `master_en` as they stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wr_data | input | 8 | Enable register write data |
| clr_wr | input | 1 | Pending clear strobe |
| clr_wr_data | input | 8 | Write-1-to-clear mask for pending flags |
| en_rd | output | 8 | Enable register contents |
| pend_rd | output | 8 | Pending flags |
| ev_attn_lo | input | 1 | Low-priority attention event |
| ev_attn_hi | input | 1 | High-priority attention event |
| ev_lm0 | input | 1 | Location monitor 0 hit |
| ev_lm1 | input | 1 | Location monitor 1 hit |
| ev_iack_done | input | 1 | Outgoing interrupt acknowledged |
| sysfail_n | input | 1 | System-fail line, active low |
| ev_wperr | input | 1 | Bus error on posted write |
| lvl_lm0 | input | 3 | Level for location monitor 0 |
| lvl_lm1 | input | 3 | Level for location monitor 1 |
| lvl_iack | input | 3 | Level for acknowledge-complete |
| lvl_sysfail | input | 3 | Level for system fail |
| master_en | input | 1 | Master interrupt enable |
| irq_level | output | 3 | Highest active interrupt level |

## Verification
The bench walks every source through each combination of its enable bit and the master enable. A design that drops masked events would show an empty `pend_rd`. A design that ignores the master gate would show a nonzero level. With every flag pending, the bench sweeps all 128 enable masks and checks the arithmetic maximum, which exposes a wrong priority order or a wrong fixed level. It also sweeps every programmable level value, including 0. It then checks a clear that lands on the same edge as a new event, which a clear-wins design would lose. Finally it checks a system-fail line held low after a clear, which a level-sensitive design would set again.

// File: rtl/util_irq_pkg.sv
// Package: shared widths, source positions and fixed levels for the
// utility interrupt block. Assumes one source per enable bit, bit 0 unused.
package util_irq_pkg;
    localparam int NUM_SRC = 8;
    localparam int LVL_W   = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam int SRC_RSVD    = 0;
    localparam int SRC_ATTN_LO = 1;
    localparam int SRC_LM0     = 2;
    localparam int SRC_IACK    = 3;
    localparam int SRC_LM1     = 4;
    localparam int SRC_ATTN_HI = 5;
    localparam int SRC_SYSFAIL = 6;
    localparam int SRC_WPERR   = 7;

    localparam lvl_t LVL_ATTN_LO = 3'd1;
    localparam lvl_t LVL_ATTN_HI = 3'd5;
    localparam lvl_t LVL_WPERR   = 3'd7;

    localparam logic [NUM_SRC-1:0] RSVD_MASK = NUM_SRC'(1) << SRC_RSVD;
endpackage

// File: rtl/util_irq_enable_reg.sv
// Enable register: holds one enable bit per source, loaded whole on a
// write strobe. Assumes reserved bits are forced to zero on every write.
module util_irq_enable_reg
    import util_irq_pkg::*;
#(
    parameter int W = NUM_SRC,
    parameter logic [W-1:0] ZERO_MASK = RSVD_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] en_q
);
    // Load the register on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr)
            en_q <= wr_data & ~ZERO_MASK;
    end
endmodule

// File: rtl/util_irq_pending.sv
// Pending flags: one sticky flag per source, set on a rising edge of its
// event and cleared by a write-1-to-clear mask. A set wins over a clear.
// Assumes event inputs are already synchronous to clk.
module util_irq_pending
    import util_irq_pkg::*;
#(
    parameter int W = NUM_SRC,
    parameter logic [W-1:0] ZERO_MASK = RSVD_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         clr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] pend_q
);
    logic [W-1:0] ev_prev;

    // Keep last sampled event levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ev_prev <= '0;
        else
            ev_prev <= ev;
    end

    for (genvar i = 0; i < W; i++) begin : g_flag
        if (ZERO_MASK[i]) begin : g_rsvd
            assign pend_q[i] = 1'b0;
        end else begin : g_live
            logic flag_q;
            logic rise;
            assign rise = ev[i] & ~ev_prev[i];
            // Sticky flag: set on rise, cleared by mask, set has priority.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else if (rise)
                    flag_q <= 1'b1;
                else if (clr && clr_mask[i])
                    flag_q <= 1'b0;
            end
            assign pend_q[i] = flag_q;
        end
    end
endmodule

// File: rtl/util_irq_level_enc.sv
// Level encoder: picks the highest level among active sources and
// registers it. Assumes a level of 0 means "no request".
module util_irq_level_enc
    import util_irq_pkg::*;
#(
    parameter int W = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] active,
    input  lvl_t         src_lvl [W],
    output lvl_t         level_q
);
    lvl_t best;

    // Find the maximum level across active sources.
    always_comb begin
        best = '0;
        for (int i = 0; i < W; i++) begin
            if (active[i] && (src_lvl[i] > best))
                best = src_lvl[i];
        end
    end

    // Register the chosen level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else
            level_q <= best;
    end
endmodule

// File: rtl/util_irq_ctrl.sv
// Top: utility interrupt mask and level encoder. Gathers seven sources,
// latches them as pending, masks with the enable register and the master
// enable, and presents the highest active level. Assumes all inputs are
// synchronous to clk.
module util_irq_ctrl
    import util_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_wr,
    input  logic [NUM_SRC-1:0]  en_wr_data,
    input  logic                clr_wr,
    input  logic [NUM_SRC-1:0]  clr_wr_data,
    output logic [NUM_SRC-1:0]  en_rd,
    output logic [NUM_SRC-1:0]  pend_rd,
    input  logic                ev_attn_lo,
    input  logic                ev_attn_hi,
    input  logic                ev_lm0,
    input  logic                ev_lm1,
    input  logic                ev_iack_done,
    input  logic                sysfail_n,
    input  logic                ev_wperr,
    input  logic [LVL_W-1:0]    lvl_lm0,
    input  logic [LVL_W-1:0]    lvl_lm1,
    input  logic [LVL_W-1:0]    lvl_iack,
    input  logic [LVL_W-1:0]    lvl_sysfail,
    input  logic                master_en,
    output logic [LVL_W-1:0]    irq_level
);
    logic [NUM_SRC-1:0] ev_vec;
    logic [NUM_SRC-1:0] active;
    lvl_t               src_lvl [NUM_SRC];

    // Gather event lines into source-indexed vector (system fail inverted).
    always_comb begin
        ev_vec               = '0;
        ev_vec[SRC_ATTN_LO]  = ev_attn_lo;
        ev_vec[SRC_LM0]      = ev_lm0;
        ev_vec[SRC_IACK]     = ev_iack_done;
        ev_vec[SRC_LM1]      = ev_lm1;
        ev_vec[SRC_ATTN_HI]  = ev_attn_hi;
        ev_vec[SRC_SYSFAIL]  = ~sysfail_n;
        ev_vec[SRC_WPERR]    = ev_wperr;
    end

    // Map each source to its fixed or programmed level.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) src_lvl[i] = '0;
        src_lvl[SRC_ATTN_LO] = LVL_ATTN_LO;
        src_lvl[SRC_LM0]     = lvl_lm0;
        src_lvl[SRC_IACK]    = lvl_iack;
        src_lvl[SRC_LM1]     = lvl_lm1;
        src_lvl[SRC_ATTN_HI] = LVL_ATTN_HI;
        src_lvl[SRC_SYSFAIL] = lvl_sysfail;
        src_lvl[SRC_WPERR]   = LVL_WPERR;
    end

    util_irq_enable_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (en_wr),
        .wr_data (en_wr_data),
        .en_q    (en_rd)
    );

    util_irq_pending u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev_vec),
        .clr      (clr_wr),
        .clr_mask (clr_wr_data),
        .pend_q   (pend_rd)
    );

    // Qualify pending flags by enables and the master gate.
    assign active = pend_rd & en_rd & {NUM_SRC{master_en}};

    util_irq_level_enc u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .src_lvl (src_lvl),
        .level_q (irq_level)
    );
endmodule

// File: rtl/util_irq_ctrl_chk.sv
// Checker: temporal properties of the utility interrupt block, bound to
// the top module. Observes ports only.
module util_irq_ctrl_chk
    import util_irq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                clr_wr,
    input logic [NUM_SRC-1:0]  clr_wr_data,
    input logic [NUM_SRC-1:0]  en_rd,
    input logic [NUM_SRC-1:0]  pend_rd,
    input logic                master_en,
    input logic [LVL_W-1:0]    irq_level
);
    logic [NUM_SRC-1:0] keep;
    assign keep = pend_rd & ~({NUM_SRC{clr_wr}} & clr_wr_data);

    // Reserved bit 0 never set in enable or pending (R1).
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rd[SRC_RSVD] == 1'b0) && (pend_rd[SRC_RSVD] == 1'b0));

    // Reset clears state on the following cycle (R2).
    assert_reset_clear_R2: assert property (@(posedge clk)
        !rst_n |=> (en_rd == '0) && (pend_rd == '0) && (irq_level == '0));

    // Flags not cleared stay set (R3).
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_rd & $past(keep)) == $past(keep)));

    // Enabled pending posted-write error gives level 7 (R5).
    assert_wperr_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && pend_rd[SRC_WPERR] && en_rd[SRC_WPERR]) |=> (irq_level == 3'd7));

    // Master gate closed means no level next cycle (R8).
    assert_master_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (irq_level == '0));

    // No qualified source means level 0 next cycle (R9).
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_rd & en_rd) == '0) |=> (irq_level == '0));
endmodule

bind util_irq_ctrl util_irq_ctrl_chk chk_i (.*);

// File: tb/util_irq_ctrl_tb_top.sv
module util_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr = 0, clr_wr = 0;
    logic [7:0] en_wr_data = 0, clr_wr_data = 0;
    logic [7:0] en_rd, pend_rd;
    logic       ev_attn_lo = 0, ev_attn_hi = 0, ev_lm0 = 0, ev_lm1 = 0;
    logic       ev_iack_done = 0, sysfail_n = 1, ev_wperr = 0;
    logic [2:0] lvl_lm0 = 3'd2, lvl_lm1 = 3'd4, lvl_iack = 3'd3, lvl_sysfail = 3'd6;
    logic       master_en = 0;
    logic [2:0] irq_level;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    util_irq_ctrl dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_src(input int i, input logic v);
        case (i)
            1: ev_attn_lo = v;
            2: ev_lm0 = v;
            3: ev_iack_done = v;
            4: ev_lm1 = v;
            5: ev_attn_hi = v;
            6: sysfail_n = ~v;
            7: ev_wperr = v;
            default: ;
        endcase
    endtask

    task automatic write_en(input logic [7:0] v);
        en_wr = 1; en_wr_data = v; tick(); en_wr = 0;
    endtask

    task automatic clear_all();
        clr_wr = 1; clr_wr_data = 8'hFF; tick(); clr_wr = 0;
    endtask

    task automatic pulse(input int i);
        set_src(i, 1); tick(); set_src(i, 0);
    endtask

    function automatic int src_lvl(input int i);
        case (i)
            1: return 1;
            2: return lvl_lm0;
            3: return lvl_iack;
            4: return lvl_lm1;
            5: return 5;
            6: return lvl_sysfail;
            7: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_level(input logic [7:0] p, input logic [7:0] e, input logic m);
        int best = 0;
        if (!m) return 0;
        for (int i = 1; i < 8; i++)
            if (p[i] && e[i] && src_lvl(i) > best) best = src_lvl(i);
        return best;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        tick(); tick();
        // R2: reset state
        chk("R2 en", en_rd, 0); chk("R2 pend", pend_rd, 0); chk("R2 lvl", irq_level, 0);
        rst_n = 1; tick();

        // R1: write/readback, bit 0 reserved
        write_en(8'hFF); chk("R1 readback", en_rd, 8'hFE);
        write_en(8'h5A); chk("R1 readback", en_rd, 8'h5A);

        // R3/R5/R6/R8/R9: each source x enable x master
        for (int i = 1; i < 8; i++)
            for (int e = 0; e < 2; e++)
                for (int m = 0; m < 2; m++) begin
                    clear_all();
                    write_en(e ? (8'h1 << i) : 8'h0);
                    master_en = m[0];
                    pulse(i);
                    chk("R3 pend set", pend_rd, 8'h1 << i);
                    tick();
                    chk("R9 level", irq_level, (e && m) ? src_lvl(i) : 0);
                    tick();
                    chk("R3 sticky", pend_rd, 8'h1 << i);
                end

        // R9/R5: all pending, sweep all enable masks
        clear_all(); master_en = 1;
        for (int i = 1; i < 8; i++) set_src(i, 1);
        tick();
        for (int i = 1; i < 8; i++) set_src(i, 0);
        chk("R3 all pend", pend_rd, 8'hFE);
        for (int msk = 0; msk < 128; msk++) begin
            write_en(8'(msk << 1)); tick();
            chk("R9 mask sweep", irq_level, exp_level(8'hFE, 8'(msk << 1), 1'b1));
        end

        // R8: master off with everything enabled
        write_en(8'hFE); master_en = 0; tick();
        chk("R8 gate", irq_level, 0);
        master_en = 1; tick();
        chk("R5 top", irq_level, 7);

        // R6: sweep programmable level of lm0 alone, including 0
        write_en(8'h1 << 2);
        for (int v = 0; v < 8; v++) begin
            lvl_lm0 = 3'(v); tick();
            chk("R6 lm0 level", irq_level, v);
        end
        lvl_lm0 = 3'd2;

        // R4: partial clear
        clr_wr = 1; clr_wr_data = 8'h0F; tick(); clr_wr = 0;
        chk("R4 clear mask", pend_rd, 8'hF0);

        // R4: set wins over simultaneous clear
        clear_all();
        set_src(5, 1); clr_wr = 1; clr_wr_data = 8'h20; tick();
        clr_wr = 0; set_src(5, 0);
        chk("R4 set wins", pend_rd, 8'h20);

        // R7: held-low system fail does not re-set after clear
        clear_all();
        sysfail_n = 0; tick();
        chk("R7 fall sets", pend_rd, 8'h40);
        clear_all(); tick();
        chk("R7 held low", pend_rd, 0);
        sysfail_n = 1; tick(); sysfail_n = 0; tick();
        chk("R7 new fall", pend_rd, 8'h40);
        sysfail_n = 1;

        // R3: masked source still records
        clear_all(); write_en(8'h00); pulse(4);
        chk("R3 masked record", pend_rd, 8'h10);
        tick(); chk("R3 masked level", irq_level, 0);

        // R2: reset mid-run
        write_en(8'hFE); rst_n = 0; tick(); rst_n = 1;
        chk("R2 en", en_rd, 0); chk("R2 pend", pend_rd, 0); chk("R2 lvl", irq_level, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule